// File: doc/BRIEF.md
# Burst Column Address Generator

This block produces the column address sequence for a single burst access to a synchronous DRAM row. A one-cycle start pulse, sampled on a rising clock edge while the block is idle, captures a start column, a burst-length code and an ordering select. From the next cycle on, the block presents one column address per clock with a valid strobe. On the final beat of a fixed-length burst it also raises a last-beat flag.

Fixed bursts of 1, 2, 4 or 8 beats stay inside the aligned block that holds the start column. The low bits advance in sequential or interleaved (XOR) order, and the upper bits never change. The full-page setting walks through all 256 columns of the row and wraps back to column 0. It keeps going until the terminate input ends it. Terminate can also cut a fixed burst short. The block cannot interleave a full-page burst. It runs such a request as a sequential full-page burst and raises an error flag that stays set until reset.

Top module: `burst_col_gen`

## Requirements
- R1: After reset, col_valid_o, last_o and cfg_err_o are low.
- R2: A start_i sampled high while col_valid_o is low is accepted. In the following cycle col_valid_o is high and col_o equals the captured start column, and one new address follows per clock.
- R3: bl_code_i encoding: 0 gives 1 beat, 1 gives 2 beats, 2 gives 4 beats and 3 gives 8 beats. Any code with bit 2 set selects full page. A fixed burst with no terminate presents exactly N beats, raises last_o only on beat N-1, and drops col_valid_o in the next cycle.
- R4: When ilv_i is 0 and the burst is fixed length N, beat k has low log2(N) bits equal to (start + k) mod N. The upper column bits equal those of the start column throughout.
- R5: When ilv_i is 1 and the burst is fixed length N, beat k has low log2(N) bits equal to the start column's low bits XOR k. The upper column bits equal those of the start column.
- R6: In full page, beat k is (start + k) mod 256 and last_o stays low. The burst continues until terminated.
- R7: If term_i is sampled high while col_valid_o is high, the current beat is the final one and col_valid_o is low in the next cycle.
- R8: If start_i is high while col_valid_o is high, including on the last beat, it is ignored and the running sequence is unchanged.
- R9: A full-page request with ilv_i at 1 runs as sequential full page. It sets cfg_err_o, which then stays high until reset; legal requests never set it.
- R10: start_col_i, bl_code_i and ilv_i are sampled only at an accepted start. Changes to them during a burst have no effect on col_o or last_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Burst start pulse |
| start_col_i | input | COL_W | First column of the burst |
| bl_code_i | input | 3 | Burst-length code (see R3) |
| ilv_i | input | 1 | 1 = interleaved ordering, 0 = sequential |
| term_i | input | 1 | Early terminate |
| col_valid_o | output | 1 | Column address valid (burst active) |
| col_o | output | COL_W | Current column address |
| last_o | output | 1 | Final beat of a fixed-length burst |
| cfg_err_o | output | 1 | Sticky illegal-configuration flag |

## Verification
The hardest situation to reach is a burst that is disturbed while it runs. The configuration inputs change, and a second start arrives on the very beat where the burst ends. Either could leak into the next address. The stimulus sweeps every start column with every fixed length and both orderings. On every seventh start column it scrambles all configuration inputs and holds start high throughout the burst, including its last beat. Full page is driven past the 255-to-0 wrap twice before it is terminated, and the illegal interleaved full-page request comes only after the legal sweep, so the sticky flag can be seen clear and then set.

// File: rtl/bcg_pkg.sv
package bcg_pkg;
    localparam int CODE_W     = 3;
    localparam int FIXED_SELW = 2;

    typedef enum logic {
        ORDER_SEQ = 1'b0,
        ORDER_ILV = 1'b1
    } order_e;
endpackage

// File: rtl/bcg_cfg_dec.sv
module bcg_cfg_dec
    import bcg_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic [CODE_W-1:0] bl_code_i,
    input  logic              ilv_req_i,
    output logic [COL_W-1:0]  mask_o,
    output logic              full_o,
    output order_e            order_o,
    output logic              illegal_o
);
    logic full_sel;

    assign full_sel  = bl_code_i[CODE_W-1];
    assign full_o    = full_sel;
    assign illegal_o = full_sel & ilv_req_i;
    assign order_o   = (ilv_req_i && !full_sel) ? ORDER_ILV : ORDER_SEQ;

    // Burst-index mask: bit i is inside the burst when i < log2(length).
    for (genvar i = 0; i < COL_W; i++) begin : g_mask
        assign mask_o[i] = full_sel | (i < int'(bl_code_i[FIXED_SELW-1:0]));
    end

    always_comb begin
        if (!full_sel) begin
            assert ((mask_o & (mask_o + 1'b1)) == '0);
        end
    end
endmodule

// File: rtl/bcg_addr_calc.sv
module bcg_addr_calc
    import bcg_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0] base_i,
    input  logic [COL_W-1:0] beat_i,
    input  logic [COL_W-1:0] mask_i,
    input  order_e           order_i,
    output logic [COL_W-1:0] col_o
);
    logic [COL_W-1:0] sum;

    assign sum = base_i + beat_i;

    for (genvar i = 0; i < COL_W; i++) begin : g_bit
        always_comb begin
            if (!mask_i[i]) begin
                col_o[i] = base_i[i];
            end else if (order_i == ORDER_ILV) begin
                col_o[i] = base_i[i] ^ beat_i[i];
            end else begin
                col_o[i] = sum[i];
            end
        end
    end
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
    import bcg_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [COL_W-1:0]  start_col_i,
    input  logic [CODE_W-1:0] bl_code_i,
    input  logic              ilv_i,
    input  logic              term_i,
    output logic              col_valid_o,
    output logic [COL_W-1:0]  col_o,
    output logic              last_o,
    output logic              cfg_err_o
);
    typedef struct packed {
        logic             busy;
        logic             full;
        order_e           order;
        logic             err;
        logic [COL_W-1:0] mask;
        logic [COL_W-1:0] base;
        logic [COL_W-1:0] beat;
    } state_t;

    state_t st_d, st_q;

    logic [COL_W-1:0] dec_mask;
    logic             dec_full;
    order_e           dec_order;
    logic             dec_illegal;
    logic             end_beat;

    bcg_cfg_dec #(.COL_W(COL_W)) u_dec (
        .bl_code_i (bl_code_i),
        .ilv_req_i (ilv_i),
        .mask_o    (dec_mask),
        .full_o    (dec_full),
        .order_o   (dec_order),
        .illegal_o (dec_illegal)
    );

    bcg_addr_calc #(.COL_W(COL_W)) u_calc (
        .base_i  (st_q.base),
        .beat_i  (st_q.beat),
        .mask_i  (st_q.mask),
        .order_i (st_q.order),
        .col_o   (col_o)
    );

    assign end_beat    = !st_q.full && (st_q.beat == st_q.mask);
    assign col_valid_o = st_q.busy;
    assign last_o      = st_q.busy && end_beat;
    assign cfg_err_o   = st_q.err;

    always_comb begin
        st_d = st_q;
        if (!st_q.busy) begin
            if (start_i) begin
                st_d.busy  = 1'b1;
                st_d.full  = dec_full;
                st_d.order = dec_order;
                st_d.mask  = dec_mask;
                st_d.base  = start_col_i;
                st_d.beat  = '0;
                st_d.err   = st_q.err | dec_illegal;
            end
        end else if (term_i || end_beat) begin
            st_d.busy = 1'b0;
        end else begin
            st_d.beat = st_q.beat + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_FIRST_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        (!col_valid_o && start_i) |=> (col_valid_o && col_o == $past(start_col_i))); // R2
    AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |=> !col_valid_o); // R3
    AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid_o && !last_o && !term_i) |=>
        (col_valid_o && ((col_o & ~st_q.mask) == ($past(col_o) & ~st_q.mask)))); // R4
    AST_TERM_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid_o && term_i) |=> !col_valid_o); // R7
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err_o |=> cfg_err_o); // R9
endmodule

// File: tb/burst_col_gen_tb.sv
module burst_col_gen_tb;
    localparam int CLK_PERIOD = 10;
    localparam int COL_W      = 8;
    localparam int WATCHDOG   = 150000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [COL_W-1:0] start_col_i = '0;
    logic [2:0]       bl_code_i = '0;
    logic             ilv_i = 1'b0;
    logic             term_i = 1'b0;
    logic             col_valid_o;
    logic [COL_W-1:0] col_o;
    logic             last_o;
    logic             cfg_err_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_col_gen #(.COL_W(COL_W)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .start_col_i (start_col_i),
        .bl_code_i   (bl_code_i),
        .ilv_i       (ilv_i),
        .term_i      (term_i),
        .col_valid_o (col_valid_o),
        .col_o       (col_o),
        .last_o      (last_o),
        .cfg_err_o   (cfg_err_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Runs one burst. term_at < 0 means no terminate. noise scrambles config and holds start.
    task automatic run_burst(input int sc, input int code, input bit ilv,
                             input int term_at, input bit noise);
        bit fixed;
        int n, mask, exp_col, beat;
        bit done;
        fixed = (code < 4);
        n     = fixed ? (1 << code) : 256;
        mask  = n - 1;
        @(negedge clk);
        start_i = 1'b1; start_col_i = COL_W'(sc); bl_code_i = 3'(code); ilv_i = ilv;
        @(negedge clk);
        start_i = 1'b0;
        beat = 0; done = 1'b0;
        while (!done) begin
            if (!fixed)
                exp_col = (sc + beat) & 255;
            else if (ilv)
                exp_col = (sc & ~mask) | ((sc ^ beat) & mask);
            else
                exp_col = (sc & ~mask) | ((sc + beat) & mask);
            if (beat == 0)
                chk(col_valid_o && col_o == COL_W'(sc), "R2", int'(col_o), sc);
            chk(col_valid_o == 1'b1, "R3", int'(col_valid_o), 1);
            if (!fixed)
                chk(col_o == COL_W'(exp_col), "R6", int'(col_o), exp_col);
            else if (ilv)
                chk(col_o == COL_W'(exp_col), noise ? "R5/R10" : "R5", int'(col_o), exp_col);
            else
                chk(col_o == COL_W'(exp_col), noise ? "R4/R10" : "R4", int'(col_o), exp_col);
            chk(last_o == (fixed && beat == n - 1), fixed ? "R3" : "R6",
                int'(last_o), int'(fixed && beat == n - 1));
            if (noise) begin
                start_i = 1'b1;
                start_col_i = ~COL_W'(sc + beat);
                bl_code_i = 3'(code ^ 3'b101);
                ilv_i = ~ilv;
            end
            term_i = (beat == term_at);
            done = (beat == term_at) || (fixed && beat == n - 1);
            @(negedge clk);
            beat++;
        end
        start_i = 1'b0; term_i = 1'b0;
        chk(col_valid_o == 1'b0, term_at >= 0 ? "R7" : (noise ? "R8" : "R3"),
            int'(col_valid_o), 0);
    endtask

    initial begin
        while (cycles < WATCHDOG) begin
            @(posedge clk);
            cycles++;
        end
        errors++;
        $display("FAIL watchdog: actual=%0d expected=<%0d cycles", cycles, WATCHDOG);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!col_valid_o && !last_o && !cfg_err_o, "R1",
            int'({col_valid_o, last_o, cfg_err_o}), 0);

        // Sweep every start column, every fixed length, both orderings.
        for (int sc = 0; sc < 256; sc++)
            for (int code = 0; code < 4; code++)
                for (int o = 0; o < 2; o++)
                    run_burst(sc, code, o[0], -1, (sc % 7) == 0);
        chk(cfg_err_o == 1'b0, "R9", int'(cfg_err_o), 0);

        // Early terminate on fixed bursts.
        run_burst(8'h35, 3, 1'b0, 2, 1'b0);
        run_burst(8'hC6, 3, 1'b1, 0, 1'b0);
        run_burst(8'h11, 2, 1'b0, 1, 1'b1);

        // Full page across two row wraps, and the alternate full-page code.
        run_burst(250, 4, 1'b0, 300, 1'b0);
        run_burst(3, 7, 1'b0, 5, 1'b1);
        chk(cfg_err_o == 1'b0, "R9", int'(cfg_err_o), 0);

        // Illegal interleaved full page runs sequential and sets the sticky flag.
        run_burst(254, 4, 1'b1, 9, 1'b0);
        chk(cfg_err_o == 1'b1, "R9", int'(cfg_err_o), 1);
        run_burst(40, 2, 1'b1, -1, 1'b0);
        repeat (3) @(negedge clk);
        chk(cfg_err_o == 1'b1, "R9", int'(cfg_err_o), 1);

        // Reset clears everything again.
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!col_valid_o && !last_o && !cfg_err_o, "R1",
            int'({col_valid_o, last_o, cfg_err_o}), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule